// File: doc/BRIEF.md
# Cascadable 8-bit ALU Slice

This block is a purely combinational arithmetic-logic unit working on two 8-bit operands. A 3-bit operation code selects one of eight functions: add, subtract, bitwise AND, OR and XOR, inversion of A, and a one-place shift of A in either direction. The 8-bit result is always accompanied by a Zero flag and a Negative flag, and both are derived from the result that leaves the block.

Two identical slices combine into a 16-bit ALU. Addition and subtraction each have their own carry input and carry output, so the two chains never share a wire. Each shift also has a fill input, so a bit can cross the byte boundary in either direction. For a 16-bit build, the low slice's add carry-out drives the high slice's add carry-in, and the low slice's subtract carry-out drives the high slice's subtract carry-in. Bit 7 of A drives the high slice's left-shift fill, and bit 8 of A drives the low slice's right-shift fill. The 16-bit Zero flag is the AND of the two slice Zero flags.

A slice used on its own must tie its subtract carry-in to 1 and both fill inputs to 0. It then computes plain A-B, and shifts bring in zeros.

Top module: `alu_slice8`

## Requirements
- R1: With op 000 (ADD), {add_co, res_o} equals a_i + b_i + add_ci as a 9-bit sum.
- R2: With op 001 (SUB), {sub_co, res_o} equals a_i + (~b_i) + sub_ci as a 9-bit sum. With sub_ci tied to 1, res_o is a_i - b_i modulo 256 and sub_co is 1 exactly when a_i >= b_i.
- R3: Op 010 gives a_i & b_i, op 011 gives a_i | b_i, and op 100 gives a_i ^ b_i.
- R4: Op 101 gives ~a_i, and b_i has no effect on the result.
- R5: Op 110 (shift left) gives res_o = {a_i[6:0], shl_fill}. shr_fill has no effect.
- R6: Op 111 (shift right) gives res_o = {shr_fill, a_i[7:1]}. shl_fill has no effect.
- R7: add_co is 0 for every op other than 000, and sub_co is 0 for every op other than 001. Under those ops the carry inputs do not change res_o.
- R8: zero_o is 1 exactly when all eight bits of the final res_o are 0, whatever the op.
- R9: neg_o equals res_o[7] for every op.
- R10: Two chained slices, wired as described above, give correct 16-bit add, subtract, shift left and shift right, including carries, borrows and shifted bits that cross the byte boundary. The AND of the two Zero flags is the 16-bit Zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| op_i | input | 3 | Operation code (encodings in R1 to R6) |
| add_ci | input | 1 | Carry into addition |
| sub_ci | input | 1 | Carry into subtraction (tie to 1 standalone) |
| shl_fill | input | 1 | Bit shifted into res_o[0] on shift left |
| shr_fill | input | 1 | Bit shifted into res_o[7] on shift right |
| res_o | output | 8 | Selected result |
| add_co | output | 1 | Addition carry-out, 0 unless op is ADD |
| sub_co | output | 1 | Subtraction carry-out (1 means no borrow), 0 unless op is SUB |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result bit 7 |

## Verification
Addition is tried with the carry-in at 0 and at 1. The operand pairs include one that overflows to exactly zero, which separates the carry-out and Zero flag from the sum bits. Subtraction uses equal operands, a larger A and a smaller A, which shows whether the borrow polarity and the constant-one carry-in are right. The logic operations and the shifts use alternating patterns such as 0xA5 and 0x3C, with the fill inputs and the unused operand toggled, so a wrong operand, a wrong fill source or a wrong shift direction changes the result. The chained pair runs values such as 0x00FF+0x0001, 0x0100-0x0001, a left shift of 0x0080 and a right shift of 0x0100, which are correct only if the carry, the borrow or the shifted bit actually crosses between the slices.

// File: rtl/alu_slice_pkg.sv
// Package alu_slice_pkg
// Shared operation encoding for the ALU slice and its helpers.
// Assumes a 3-bit operation code in which every value is defined.
package alu_slice_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_NOT = 3'b101,
        OP_SHL = 3'b110,
        OP_SHR = 3'b111
    } alu_op_e;
endpackage

// File: rtl/alu_ripple_adder.sv
// Module alu_ripple_adder
// Ripple-carry adder of parameterised width, built from repeated full-adder
// cells. It serves both addition and subtraction: the caller inverts B and
// supplies the carry-in.
// Assumes W >= 1. Purely combinational.
module alu_ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    logic [W:0] chain;

    assign chain[0] = c_i;

    // One full-adder cell per bit position.
    for (genvar k = 0; k < W; k++) begin : g_cell
        logic half;
        assign half         = x_i[k] ^ y_i[k];
        assign s_o[k]       = half ^ chain[k];
        assign chain[k+1]   = (x_i[k] & y_i[k]) | (half & chain[k]);
    end

    assign c_o = chain[W];
endmodule

// File: rtl/alu_bitwise.sv
// Module alu_bitwise
// Bitwise functions of the slice: AND, OR, XOR and inversion of A.
// Any other operation code gives zero, because the top-level mux never
// selects this output for those codes.
// Assumes the encoding of alu_slice_pkg.
module alu_bitwise
    import alu_slice_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] r_o
);
    // Select the bitwise function for this operation code.
    always_comb begin
        unique case (op_i)
            OP_AND:  r_o = a_i & b_i;
            OP_OR:   r_o = a_i | b_i;
            OP_XOR:  r_o = a_i ^ b_i;
            OP_NOT:  r_o = ~a_i;
            default: r_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
// Module alu_shifter
// Shifts A one place. left_i = 1 shifts toward the MSB and brings in
// lfill_i at bit 0. left_i = 0 shifts toward the LSB and brings in
// rfill_i at the MSB. The fill inputs let a neighbouring slice supply
// the bit that crosses the byte boundary.
// Assumes W >= 2.
module alu_shifter #(
    parameter int W = 8
) (
    input  logic         left_i,
    input  logic [W-1:0] a_i,
    input  logic         lfill_i,
    input  logic         rfill_i,
    output logic [W-1:0] r_o
);
    logic [W-1:0] up;
    logic [W-1:0] down;

    assign up   = {a_i[W-2:0], lfill_i};
    assign down = {rfill_i, a_i[W-1:1]};

    // Pick the shift direction.
    always_comb r_o = left_i ? up : down;
endmodule

// File: rtl/alu_flags.sv
// Module alu_flags
// Derives the Zero and Negative flags from the final selected result.
// Assumes two's-complement sign in the MSB.
module alu_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0] r_i,
    output logic         zero_o,
    output logic         neg_o
);
    // Zero when no bit is set; Negative is the sign bit.
    always_comb begin
        zero_o = ~(|r_i);
        neg_o  = r_i[W-1];
    end
endmodule

// File: rtl/alu_slice8.sv
// Module alu_slice8
// Cascadable combinational ALU slice. One adder serves both ADD and SUB:
// for SUB, B is inverted and sub_ci is the carry-in. Each carry output
// is active only under its own operation. The shift fill inputs accept
// the bit that crosses from the neighbouring slice.
// Assumes the caller ties sub_ci to 1 and both fills to 0 when the slice
// is used on its own. No clock and no reset: the block holds no state.
module alu_slice8
    import alu_slice_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            add_ci,
    input  logic            sub_ci,
    input  logic            shl_fill,
    input  logic            shr_fill,
    output logic [W-1:0]    res_o,
    output logic            add_co,
    output logic            sub_co,
    output logic            zero_o,
    output logic            neg_o
);
    alu_op_e      op;
    logic         is_add;
    logic         is_sub;
    logic [W-1:0] y_eff;
    logic         c_eff;
    logic [W-1:0] sum;
    logic         cout;
    logic [W-1:0] bw_res;
    logic [W-1:0] sh_res;

    assign op = alu_op_e'(op_i);

    // Decode the two arithmetic operations.
    always_comb begin
        is_add = (op == OP_ADD);
        is_sub = (op == OP_SUB);
    end

    // Prepare the adder operand and carry for add or subtract.
    always_comb begin
        y_eff = is_sub ? ~b_i : b_i;
        c_eff = is_sub ? sub_ci : add_ci;
    end

    alu_ripple_adder #(.W(W)) u_add (
        .x_i (a_i),
        .y_i (y_eff),
        .c_i (c_eff),
        .s_o (sum),
        .c_o (cout)
    );

    alu_bitwise #(.W(W)) u_bw (
        .op_i (op),
        .a_i  (a_i),
        .b_i  (b_i),
        .r_o  (bw_res)
    );

    alu_shifter #(.W(W)) u_sh (
        .left_i  (op == OP_SHL),
        .a_i     (a_i),
        .lfill_i (shl_fill),
        .rfill_i (shr_fill),
        .r_o     (sh_res)
    );

    // Final result mux across the three functional units.
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: res_o = sum;
            OP_SHL, OP_SHR: res_o = sh_res;
            default:        res_o = bw_res;
        endcase
    end

    // Each carry output is driven only under its own operation.
    always_comb begin
        add_co = is_add & cout;
        sub_co = is_sub & cout;
    end

    alu_flags #(.W(W)) u_flg (
        .r_i    (res_o),
        .zero_o (zero_o),
        .neg_o  (neg_o)
    );
endmodule

// File: rtl/alu_slice8_chk.sv
// Module alu_slice8_chk
// Assertion checker for alu_slice8, attached to every instance by the
// bind statement at the end of this file. The slice has no clock, so the
// checks are immediate assertions on settled inputs. They are skipped
// while any input is still unknown.
module alu_slice8_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [2:0]   op_i,
    input logic         add_ci,
    input logic         sub_ci,
    input logic         shl_fill,
    input logic         shr_fill,
    input logic [W-1:0] res_o,
    input logic         add_co,
    input logic         sub_co,
    input logic         zero_o,
    input logic         neg_o
);
    logic [W:0] add_ref;
    logic [W:0] sub_ref;

    // Reference sums used by the arithmetic checks.
    always_comb begin
        add_ref = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, add_ci};
        sub_ref = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, sub_ci};
    end

    // Port relations per operation and for the flags.
    always_comb begin
        if (!$isunknown({a_i, b_i, op_i, add_ci, sub_ci, shl_fill, shr_fill})) begin
            if (op_i == 3'b000) begin
                p_add_sum_r1: assert ({add_co, res_o} == add_ref)
                    else $error("add mismatch");
            end
            if (op_i == 3'b001) begin
                p_sub_sum_r2: assert ({sub_co, res_o} == sub_ref)
                    else $error("sub mismatch");
            end
            if (op_i == 3'b110) begin
                p_shl_fill_r5: assert (res_o == {a_i[W-2:0], shl_fill})
                    else $error("shl mismatch");
            end
            if (op_i == 3'b111) begin
                p_shr_fill_r6: assert (res_o == {shr_fill, a_i[W-1:1]})
                    else $error("shr mismatch");
            end
            p_carry_gate_r7: assert ((op_i == 3'b000 || !add_co) && (op_i == 3'b001 || !sub_co))
                else $error("carry out active under wrong op");
            p_zero_flag_r8: assert (zero_o == (res_o == '0))
                else $error("zero flag mismatch");
            p_neg_flag_r9: assert (neg_o == res_o[W-1])
                else $error("negative flag mismatch");
        end
    end
endmodule

bind alu_slice8 alu_slice8_chk #(.W(W)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .add_ci   (add_ci),
    .sub_ci   (sub_ci),
    .shl_fill (shl_fill),
    .shr_fill (shr_fill),
    .res_o    (res_o),
    .add_co   (add_co),
    .sub_co   (sub_co),
    .zero_o   (zero_o),
    .neg_o    (neg_o)
);

// File: tb/alu_slice8_tb.sv
// Directed bench: one slice (u_dut) tested on its own, plus two slices
// (u_lo, u_hi) chained into a 16-bit ALU.
module alu_slice8_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks   = 0;
    int failures = 0;

    // Standalone slice.
    logic [7:0] a, b, res;
    logic [2:0] op;
    logic       aci, sci, lf, rf;
    logic       aco, sco, zf, nf;

    alu_slice8 u_dut (
        .a_i(a), .b_i(b), .op_i(op), .add_ci(aci), .sub_ci(sci),
        .shl_fill(lf), .shr_fill(rf), .res_o(res), .add_co(aco),
        .sub_co(sco), .zero_o(zf), .neg_o(nf)
    );

    // Chained 16-bit pair.
    logic [15:0] a16, b16;
    logic [2:0]  op16;
    logic [7:0]  res_lo, res_hi;
    logic        lo_aco, lo_sco, hi_aco, hi_sco;
    logic        lo_z, hi_z, lo_n, hi_n;

    alu_slice8 u_lo (
        .a_i(a16[7:0]), .b_i(b16[7:0]), .op_i(op16), .add_ci(1'b0),
        .sub_ci(1'b1), .shl_fill(1'b0), .shr_fill(a16[8]),
        .res_o(res_lo), .add_co(lo_aco), .sub_co(lo_sco),
        .zero_o(lo_z), .neg_o(lo_n)
    );

    alu_slice8 u_hi (
        .a_i(a16[15:8]), .b_i(b16[15:8]), .op_i(op16), .add_ci(lo_aco),
        .sub_ci(lo_sco), .shl_fill(a16[7]), .shr_fill(1'b0),
        .res_o(res_hi), .add_co(hi_aco), .sub_co(hi_sco),
        .zero_o(hi_z), .neg_o(hi_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
                         input logic ac, input logic sc, input logic l, input logic r);
        @(negedge clk);
        op = o; a = x; b = y; aci = ac; sci = sc; lf = l; rf = r;
        #1;
    endtask

    task automatic t_idle_state;
        drive(3'b000, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 idle zero", {aco, sco, zf, nf, res}, {4'b0010, 8'h00});
    endtask

    task automatic t_add;
        logic [8:0] e;
        drive(3'b000, 8'h3C, 8'h45, 1'b0, 1'b1, 1'b0, 1'b0);
        e = 9'h081;
        chk("R1 add", {aco, res}, e);
        chk("R9 add neg", nf, 1'b1);
        drive(3'b000, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R1 add cin wrap", {aco, res}, 9'h100);
        chk("R8 add wrap zero", zf, 1'b1);
        drive(3'b000, 8'h80, 8'h7F, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1 add cin carry", {aco, res}, 9'h100);
    endtask

    task automatic t_sub;
        drive(3'b001, 8'h50, 8'h20, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R2 sub a>b", {sco, res}, 9'h130);
        drive(3'b001, 8'h20, 8'h50, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R2 sub a<b borrow", {sco, res}, 9'h0D0);
        chk("R9 sub neg", nf, 1'b1);
        drive(3'b001, 8'h77, 8'h77, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R2 sub equal", {sco, zf, res}, 10'h300);
        drive(3'b001, 8'h77, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 sub cin0", {sco, res}, 9'h0FF);
    endtask

    task automatic t_logic;
        drive(3'b010, 8'hA5, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 and", res, 8'h24);
        drive(3'b011, 8'hA5, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 or", res, 8'hBD);
        drive(3'b100, 8'hA5, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 xor", res, 8'h99);
        drive(3'b100, 8'h5A, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 xor zero", {zf, res}, 9'h100);
    endtask

    task automatic t_not;
        drive(3'b101, 8'hA5, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4 not", res, 8'h5A);
        drive(3'b101, 8'hA5, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4 not ignores b", res, 8'h5A);
        drive(3'b101, 8'hFF, 8'h12, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 not zero", {zf, nf, res}, 10'h200);
    endtask

    task automatic t_shift;
        drive(3'b110, 8'hA5, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R5 shl fill0", res, 8'h4A);
        drive(3'b110, 8'hA5, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R5 shl fill1", res, 8'h4B);
        drive(3'b111, 8'hA5, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R6 shr fill0", res, 8'h52);
        drive(3'b111, 8'hA5, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R6 shr fill1", {nf, res}, 9'h1D2);
        drive(3'b110, 8'h80, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 shl out zero", {zf, res}, 9'h100);
    endtask

    task automatic t_carry_gate;
        for (int o = 2; o < 8; o++) begin
            drive(3'(o), 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0);
            chk("R7 carries off", {aco, sco}, 2'b00);
        end
        drive(3'b001, 8'hFF, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R7 add_co off in sub", aco, 1'b0);
        drive(3'b000, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7 sub_co off in add", sco, 1'b0);
        drive(3'b011, 8'h12, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 cin ignored in or", res, 8'h52);
    endtask

    task automatic chain(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y,
                         input logic [16:0] exp, input string tag);
        @(negedge clk);
        op16 = o; a16 = x; b16 = y;
        #1;
        chk(tag, {(o == 3'b000) ? hi_aco : hi_sco, res_hi, res_lo}, exp);
    endtask

    task automatic t_chain16;
        chain(3'b000, 16'h00FF, 16'h0001, 17'h00100, "R10 add cross carry");
        chain(3'b000, 16'hFFFF, 16'h0001, 17'h10000, "R10 add full carry");
        chk("R10 zero16", lo_z & hi_z, 1'b1);
        chain(3'b001, 16'h0100, 16'h0001, 17'h100FF, "R10 sub cross borrow");
        chain(3'b001, 16'h0001, 16'h0002, 17'h0FFFF, "R10 sub negative");
        chk("R10 neg16", hi_n, 1'b1);
        chain(3'b110, 16'h0080, 16'h0000, 17'h00100, "R10 shl cross");
        chain(3'b110, 16'h4321, 16'h0000, 17'h08642, "R10 shl wide");
        chain(3'b111, 16'h0100, 16'h0000, 17'h00080, "R10 shr cross");
        chain(3'b111, 16'h8642, 16'h0000, 17'h04321, "R10 shr wide");
        chain(3'b001, 16'h1234, 16'h1234, 17'h10000, "R10 sub equal");
        chk("R10 zero16 sub", lo_z & hi_z, 1'b1);
        chain(3'b000, 16'h0100, 16'h0000, 17'h00100, "R10 add low zero");
        chk("R10 zero16 partial", lo_z & hi_z, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        a = '0; b = '0; op = '0; aci = 1'b0; sci = 1'b1; lf = 1'b0; rf = 1'b0;
        a16 = '0; b16 = '0; op16 = '0;
        repeat (2) @(posedge clk);
        t_idle_state();
        t_add();
        t_sub();
        t_logic();
        t_not();
        t_shift();
        t_carry_gate();
        t_chain16();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule